// File: doc/BRIEF.md
# Leading-Zero Counter, 48-bit Halving Tree

The block counts how many zero bits precede the most significant set bit of a 48-bit operand, scanning from bit 47 downward. A typical use is the normalisation step after a mantissa product, where the count gives the left-shift amount and the exponent correction.

The count is built by a chain of compare-and-select stages rather than a flat priority encoder. A head stage decides whether the upper 32 bits are all clear. If they are, it credits 16 to the count and moves the lower 32 bits up. A recursive 32-bit stage then halves its operand at each level, crediting 16, 8, 4, 2 and 1, and ends in a single-bit stage that returns the inverse of its bit. A parameter selects either a purely combinational output or a registered output with one clock of latency.

Top module: `lzc48_tree`

## Requirements
- R1: `count_o` equals the number of consecutive clear bits of `data_i` counted from bit 47 toward bit 0. For a nonzero input, bit `47 - count_o` of that input is set and every bit above it is clear.
- R2: An all-zero input yields a count of exactly 48. 48 is the largest count the 6-bit output ever shows.
- R3: An input with bit 47 set yields a count of 0.
- R4: An input with only bit p set yields 47 - p, for every p from 0 to 47.
- R5: Bits below the most significant set bit have no effect on the count.
- R6: With `REG_OUT` = 1 (the default), the count for an input sampled at a rising clock edge is presented on `count_o` after that edge and held until the next edge.
- R7: While `rst_ni` is low, `count_o` is 0. The reset acts asynchronously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 48 | Operand to scan |
| count_o | output | 6 | Leading-zero count, 0 to 48 |

## Verification
A wrong stage decision shows up in the first registered result after the faulty input. A misjudged compare at one level leaves the count off by exactly that level's step of 16, 8, 4, 2 or 1. The bench therefore walks a single set bit through all 48 positions, so that every level is forced both ways. Random operands with varied leading-zero depth then catch decisions that depend on the lower bits. A mistake in the head stage alone moves every count at or above 32 by 16. The all-zero and top-bit cases expose it in one cycle.

// File: rtl/lzc_pkg.sv
package lzc_pkg;
  localparam int unsigned DATA_W = 48;
  localparam int unsigned CNT_W  = $clog2(DATA_W + 1);
  localparam int unsigned SUB_W  = 2 ** ($clog2(DATA_W) - 1);
  localparam int unsigned HEAD_STEP = DATA_W - SUB_W;

  typedef logic [DATA_W-1:0] data_t;
  typedef logic [CNT_W-1:0]  count_t;
endpackage

// File: rtl/lzc_half_stage.sv
// Power-of-two leading-zero stage; recurses on half width down to 1 bit.
module lzc_half_stage #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]        v_i,
  output logic [$clog2(W):0]  cnt_o
);
  localparam int unsigned CW = $clog2(W) + 1;

  if (W == 1) begin : g_leaf
    assign cnt_o = ~v_i;
  end else begin : g_node
    localparam int unsigned H   = W / 2;
    localparam int unsigned SCW = $clog2(H) + 1;
    localparam logic [W-1:0] LOW_ONES = {{H{1'b0}}, {H{1'b1}}};

    logic           hi_clear;
    logic [H-1:0]   next_v;
    logic [SCW-1:0] sub_cnt;

    assign hi_clear = (v_i <= LOW_ONES);
    // upper half of (v_i << H) is simply the lower half
    assign next_v   = hi_clear ? v_i[H-1:0] : v_i[W-1:H];

    lzc_half_stage #(.W(H)) u_sub (
      .v_i   (next_v),
      .cnt_o (sub_cnt)
    );

    assign cnt_o = CW'(sub_cnt) + (hi_clear ? CW'(H) : CW'(0));
  end
endmodule

// File: rtl/lzc_head_stage.sv
// Non-power-of-two head: reduces DATA_W to SUB_W with one compare step.
module lzc_head_stage
  import lzc_pkg::*;
(
  input  data_t  data_i,
  output count_t cnt_o
);
  localparam data_t LOW_ONES = data_t'((64'd1 << HEAD_STEP) - 64'd1);
  localparam int unsigned SCW = $clog2(SUB_W) + 1;

  logic             hi_clear;
  logic [SUB_W-1:0] sub_v;
  logic [SCW-1:0]   sub_cnt;

  assign hi_clear = (data_i <= LOW_ONES);
  assign sub_v    = hi_clear ? data_i[SUB_W-1:0] : data_i[DATA_W-1:HEAD_STEP];

  lzc_half_stage #(.W(SUB_W)) u_tree (
    .v_i   (sub_v),
    .cnt_o (sub_cnt)
  );

  assign cnt_o = CNT_W'(sub_cnt) + (hi_clear ? CNT_W'(HEAD_STEP) : CNT_W'(0));
endmodule

// File: rtl/lzc48_tree.sv
module lzc48_tree
  import lzc_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [CNT_W-1:0]  count_o
);
  count_t cnt_comb;

  lzc_head_stage u_head (
    .data_i (data_i),
    .cnt_o  (cnt_comb)
  );

  if (REG_OUT) begin : g_reg
    count_t cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_comb;
    end
    assign count_o = cnt_q;
  end else begin : g_comb
    assign count_o = rst_ni ? cnt_comb : '0;
  end
endmodule

// File: rtl/lzc48_tree_chk.sv
module lzc48_tree_chk
  import lzc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] data_i,
  input logic [CNT_W-1:0]  count_o
);
  data_t data_q;
  logic  vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      data_q <= data_i;
      vld_q  <= 1'b1;
    end
  end

  a_r1_lead_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && data_q != '0) |->
      (count_o < CNT_W'(DATA_W)) &&
      data_q[DATA_W - 1 - int'(count_o)] &&
      ((data_q >> (DATA_W - int'(count_o))) == '0));

  a_r2_all_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_i == '0) |=> (count_o == CNT_W'(DATA_W)));

  a_r2_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DATA_W));

  a_r3_msb_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_i[DATA_W-1] |=> (count_o == '0));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && $stable(data_q)) |-> $stable(count_o));
endmodule

bind lzc48_tree lzc48_tree_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .data_i  (data_i),
  .count_o (count_o)
);

// File: tb/lzc48_tree_tb_top.sv
module lzc48_tree_tb_top;
  localparam int DW = 48;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic [5:0]    count_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  lzc48_tree dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_i  (data_i),
    .count_o (count_o)
  );

  function automatic int ref_lz(logic [DW-1:0] v);
    for (int i = DW - 1; i >= 0; i--)
      if (v[i]) return DW - 1 - i;
    return DW;
  endfunction

  task automatic check(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: count %0d expected %0d (data %h)", req, act, exp, data_i);
    end
  endtask

  // drive between edges, result is registered at the next posedge
  task automatic apply(string req, logic [DW-1:0] v, int exp);
    @(negedge clk_i);
    data_i = v;
    @(negedge clk_i);
    check(req, int'(count_o), exp);
  endtask

  function automatic logic [DW-1:0] rnd48();
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    return r[DW-1:0];
  endfunction

  initial begin
    logic [DW-1:0] v;
    void'($urandom(32'd4711));
    data_i = {DW{1'b1}};
    repeat (3) @(negedge clk_i);
    check("R7", int'(count_o), 0);
    rst_ni = 1'b1;

    apply("R2", '0, DW);
    apply("R3", {1'b1, {(DW-1){1'b0}}}, 0);
    apply("R3", {DW{1'b1}}, 0);
    for (int p = 0; p < DW; p++) begin
      v = '0;
      v[p] = 1'b1;
      apply("R4", v, DW - 1 - p);
    end

    // R6: one-cycle latency, held while the input is unchanged
    @(negedge clk_i);
    data_i = 48'h0000_0100_0000;
    #1 check("R6", int'(count_o), 0);
    @(negedge clk_i);
    check("R6", int'(count_o), 23);
    @(negedge clk_i);
    check("R6", int'(count_o), 23);

    // R5: lower bits vary under a fixed leading one
    for (int k = 0; k < 200; k++) begin
      int p;
      p = int'($urandom_range(DW - 1, 0));
      v = rnd48() & ((48'd1 << p) - 48'd1);
      v[p] = 1'b1;
      apply("R5", v, DW - 1 - p);
    end

    // R1: random operands with varied leading-zero depth
    for (int k = 0; k < 600; k++) begin
      v = rnd48() >> $urandom_range(DW, 0);
      apply("R1", v, ref_lz(v));
    end

    apply("R2", '0, DW);

    // R7: asynchronous reset mid-run
    @(negedge clk_i);
    data_i = 48'h0000_0000_0001;
    @(negedge clk_i);
    check("R1", int'(count_o), 47);
    #1 rst_ni = 1'b0;
    #0.5 check("R7", int'(count_o), 0);
    @(negedge clk_i);
    check("R7", int'(count_o), 0);
    rst_ni = 1'b1;
    apply("R1", 48'h0000_8000_0000, 16);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: count %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule